// File: doc/BRIEF.md
# Sixteen-Pin Port Expander Register Core

This block is the register and pin-control core of a port expander with two byte-wide ports, sixteen pins in all. A host reaches it through a plain byte register bus: an address, write data, a write strobe, a read strobe and registered read data. A serial slave front-end is expected to sit in front of this bus. Per port, the block keeps an output-level register, a direction register, an interrupt-mask register and a function-select register. It also holds one global drive-style bit and exposes a fixed identifier byte. From these registers it computes an output enable and a level for every pin.

Every pin input passes through a two-flop synchronizer. An unmasked pin raises a level-type, active-low interrupt when its synchronized level differs from a per-port snapshot, in either direction. Reading a port's input register takes a new snapshot for that port, which clears that port's pending changes.

The block can be reset in two ways. A soft reset is a write of zero to the reset address. A hardware reset comes from an active-low pin that passes through a deglitching state machine with four states. `RS_RUN` is normal operation. A low pin moves the machine to `RS_FILTER` (transition *low_seen*), where a counter measures the low time. If the pin returns high first, the machine goes back to `RS_RUN` (*glitch_drop*). Once the pin has been low for `FILT_CYCLES`, the machine moves to `RS_HELD` (*filter_done*), and the registers are held at their defaults. When the pin is released, the machine moves to `RS_RECOVER` (*released*), where register access is blocked for `REC_CYCLES`. After that it returns to `RS_RUN` (*recovered*). A new low pin during `RS_RECOVER` sends the machine back to `RS_FILTER` (*low_seen*).

Top module: `pinx_core`

## Requirements
- R1: After reset the registers hold these defaults: output levels 0x00, direction 0xFF, interrupt mask 0xFF, function select 0xFF and global control 0x00. Every `pin_oe` is 0 and `int_n` is 1.
- R2: A read of address 0x10 returns 0x23, and writes to 0x10 leave it unchanged. Read data appears on `reg_rdata` on the clock edge that samples `reg_rd`, and it holds until the next read.
- R3: Reads of unmapped addresses, including 0x7F, return 0x00. Writes to unmapped addresses change no register.
- R4: Addresses 0x00 and 0x01 read the synchronized levels of pins 7..0 and 15..8; pin n is bit n%8 of port n>>3. Writes to these addresses are ignored.
- R5: A pin is driven when its direction bit (0x04/0x05) is 0 and its function bit (0x12/0x13) is 1. In push-pull drive it outputs `pin_oe`=1 and `pin_out` equal to its output-level bit (0x02/0x03). Port 1 is always push-pull. Port 0 is push-pull when bit 4 of 0x11 is 1.
- R6: When bit 4 of 0x11 is 0, port 0 is open-drain. A driven pin whose level bit is 0 gives `pin_oe`=1 and `pin_out`=0. A driven pin whose level bit is 1 gives `pin_oe`=0. `pin_out` of port 0 stays 0.
- R7: A function bit of 0, or a direction bit of 1, gives `pin_oe`=0 and `pin_out`=0 for that pin.
- R8: `int_n` goes low when the synchronized level of a pin whose mask bit (0x06/0x07) is 0 differs from its port's snapshot, whether the pin rose or fell. Pins whose mask bit is 1 never pull `int_n` low.
- R9: Reading a port's input address snapshots that port only. `int_n` returns high once no unmasked pin differs from its snapshot, and a change still pending on the other port keeps `int_n` low.
- R10: Writing 0x00 to 0x7F restores all R1 defaults. Writing any other value to 0x7F has no effect.
- R11: Holding `hw_rst_n` low for more than `FILT_CYCLES` cycles restores the R1 defaults. A shorter low pulse changes no register.
- R12: For `REC_CYCLES` cycles after `hw_rst_n` is released from an accepted reset, writes are ignored and reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| hw_rst_n | input | 1 | Active-low hardware reset pin, deglitched |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Pin input levels, asynchronous |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin driven level |
| int_n | output | 1 | Active-low level interrupt |

## Verification
The drive logic is tried with three configurations: port 1 with mixed directions in push-pull, port 0 with all pins as outputs in push-pull, and the same port 0 pattern in open-drain. The open-drain case shows that level-1 pins release while level-0 pins pull low. Clearing the upper function bits on that same pattern shows that the function select overrides direction.

The interrupt path is tried with a rising change on each port and then a falling change, which separates per-port clearing from global clearing. It is also tried with a toggle on a masked pin. For the reset filter, a low pulse of half the filter length is compared against one longer than the filter, and writes are tried during the recovery window.

// File: rtl/pinx_pkg.sv
package pinx_pkg;

    typedef enum logic [1:0] {
        RS_RUN,
        RS_FILTER,
        RS_HELD,
        RS_RECOVER
    } rst_state_e;

    localparam logic [7:0] A_IN0   = 8'h00;
    localparam logic [7:0] A_OUT0  = 8'h02;
    localparam logic [7:0] A_DIR0  = 8'h04;
    localparam logic [7:0] A_MSK0  = 8'h06;
    localparam logic [7:0] A_ID    = 8'h10;
    localparam logic [7:0] A_GCTL  = 8'h11;
    localparam logic [7:0] A_MODE0 = 8'h12;
    localparam logic [7:0] A_SRST  = 8'h7F;

    localparam int PP_BIT = 4;

endpackage

// File: rtl/pinx_sync.sv
module pinx_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            stab_q <= {W{RST_VAL}};
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/pinx_rstfilt.sv
module pinx_rstfilt
    import pinx_pkg::*;
#(
    parameter int FILT_CYCLES = 2000,
    parameter int REC_CYCLES  = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_s,
    output logic core_clr,
    output logic acc_ok
);
    localparam int MAXC = (FILT_CYCLES > REC_CYCLES) ? FILT_CYCLES : REC_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    rst_state_e st_q, st_nx;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_RUN;
            cnt_q <= '0;
        end else begin
            st_q <= st_nx;
            if (st_nx != st_q || st_q == RS_RUN || st_q == RS_HELD)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            RS_RUN:     if (!hw_s) st_nx = RS_FILTER;
            RS_FILTER:  if (hw_s) st_nx = RS_RUN;
                        else if (cnt_q == CW'(FILT_CYCLES - 1)) st_nx = RS_HELD;
            RS_HELD:    if (hw_s) st_nx = RS_RECOVER;
            RS_RECOVER: if (!hw_s) st_nx = RS_FILTER;
                        else if (cnt_q == CW'(REC_CYCLES - 1)) st_nx = RS_RUN;
            default:    st_nx = RS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        core_clr = 1'b0;
        acc_ok   = 1'b0;
        unique case (st_q)
            RS_RUN:     acc_ok = 1'b1;
            RS_FILTER:  acc_ok = 1'b1;
            RS_HELD:    core_clr = 1'b1;
            RS_RECOVER: acc_ok = 1'b0;
            default:    acc_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pinx_drive.sv
module pinx_drive #(
    parameter int PORT_W     = 8,
    parameter bit OD_CAPABLE = 1'b0
) (
    input  logic [PORT_W-1:0] lvl,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] mode,
    input  logic              pp,
    output logic [PORT_W-1:0] oe,
    output logic [PORT_W-1:0] out
);
    logic              pp_eff;
    logic [PORT_W-1:0] en;

    assign pp_eff = pp || !OD_CAPABLE;
    assign en     = mode & ~dir;
    assign oe     = pp_eff ? en : (en & ~lvl);
    assign out    = pp_eff ? (en & lvl) : '0;
endmodule

// File: rtl/pinx_core.sv
module pinx_core
    import pinx_pkg::*;
#(
    parameter int          PORT_W      = 8,
    parameter int          FILT_CYCLES = 2000,
    parameter int          REC_CYCLES  = 150,
    parameter logic [7:0]  CHIP_ID     = 8'h23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_rst_n,
    input  logic [7:0]             reg_addr,
    input  logic [PORT_W-1:0]      reg_wdata,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    output logic [PORT_W-1:0]      reg_rdata,
    input  logic [2*PORT_W-1:0]    pin_in,
    output logic [2*PORT_W-1:0]    pin_oe,
    output logic [2*PORT_W-1:0]    pin_out,
    output logic                   int_n
);
    localparam int NPORT = 2;
    localparam int NPIN  = NPORT * PORT_W;

    logic [NPIN-1:0] pin_s;
    logic            hw_s;
    logic            core_clr;
    logic            acc_ok;

    pinx_sync #(.W(NPIN), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    pinx_sync #(.W(1), .RST_VAL(1'b1)) u_hw_sync (
        .clk(clk), .rst_n(rst_n), .d(hw_rst_n), .q(hw_s)
    );

    pinx_rstfilt #(.FILT_CYCLES(FILT_CYCLES), .REC_CYCLES(REC_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .hw_s(hw_s),
        .core_clr(core_clr), .acc_ok(acc_ok)
    );

    logic [NPORT-1:0][PORT_W-1:0] in_v;
    logic [NPORT-1:0][PORT_W-1:0] out_q, dir_q, msk_q, mode_q, snap_q;
    logic                         pp0_q;
    logic [PORT_W-1:0]            rdata_q;
    logic [PORT_W-1:0]            rd_mux;
    logic                         int_n_q;
    logic                         wr_ok, rd_ok, soft_clr, clr, pend;

    assign in_v     = pin_s;
    assign wr_ok    = reg_wr && acc_ok;
    assign rd_ok    = reg_rd && acc_ok;
    assign soft_clr = wr_ok && (reg_addr == A_SRST) && (reg_wdata == '0);
    assign clr      = core_clr || soft_clr;
    assign pend     = |((in_v ^ snap_q) & ~msk_q);

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '1;
            msk_q  <= '1;
            mode_q <= '1;
            pp0_q  <= 1'b0;
            snap_q <= '0;
        end else if (clr) begin
            out_q  <= '0;
            dir_q  <= '1;
            msk_q  <= '1;
            mode_q <= '1;
            pp0_q  <= 1'b0;
            snap_q <= in_v;
        end else begin
            for (int k = 0; k < NPORT; k++) begin
                if (wr_ok && reg_addr == A_OUT0 + 8'(k))  out_q[k]  <= reg_wdata;
                if (wr_ok && reg_addr == A_DIR0 + 8'(k))  dir_q[k]  <= reg_wdata;
                if (wr_ok && reg_addr == A_MSK0 + 8'(k))  msk_q[k]  <= reg_wdata;
                if (wr_ok && reg_addr == A_MODE0 + 8'(k)) mode_q[k] <= reg_wdata;
                if (rd_ok && reg_addr == A_IN0 + 8'(k))   snap_q[k] <= in_v[k];
            end
            if (wr_ok && reg_addr == A_GCTL) pp0_q <= reg_wdata[PP_BIT];
        end
    end

    // read mux
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (reg_addr == A_IN0 + 8'(k))   rd_mux = in_v[k];
            if (reg_addr == A_OUT0 + 8'(k))  rd_mux = out_q[k];
            if (reg_addr == A_DIR0 + 8'(k))  rd_mux = dir_q[k];
            if (reg_addr == A_MSK0 + 8'(k))  rd_mux = msk_q[k];
            if (reg_addr == A_MODE0 + 8'(k)) rd_mux = mode_q[k];
        end
        if (reg_addr == A_ID)   rd_mux = PORT_W'(CHIP_ID);
        if (reg_addr == A_GCTL) rd_mux[PP_BIT] = pp0_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            int_n_q <= 1'b1;
        end else begin
            if (reg_rd) rdata_q <= acc_ok ? rd_mux : '0;
            int_n_q <= clr ? 1'b1 : !pend;
        end
    end

    assign reg_rdata = rdata_q;
    assign int_n     = int_n_q;

    // per-port drivers; only port 0 can run open-drain
    for (genvar k = 0; k < NPORT; k++) begin : g_port
        pinx_drive #(.PORT_W(PORT_W), .OD_CAPABLE(k == 0)) u_drv (
            .lvl(out_q[k]), .dir(dir_q[k]), .mode(mode_q[k]), .pp(pp0_q),
            .oe(pin_oe[k*PORT_W +: PORT_W]), .out(pin_out[k*PORT_W +: PORT_W])
        );
    end
endmodule

// File: rtl/pinx_core_chk.sv
module pinx_core_chk #(
    parameter int         PORT_W  = 8,
    parameter logic [7:0] CHIP_ID = 8'h23
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          reg_addr,
    input logic                reg_rd,
    input logic [PORT_W-1:0]   reg_rdata,
    input logic [2*PORT_W-1:0] pin_out,
    input logic                int_n,
    input logic                acc_ok,
    input logic                core_clr,
    input logic                pp0,
    input logic [2*PORT_W-1:0] msk,
    input logic [2*PORT_W-1:0] dir,
    input logic [2*PORT_W-1:0] lvl
);
    logic hole;
    assign hole = !((reg_addr <= 8'h07) || (reg_addr >= 8'h10 && reg_addr <= 8'h13));

    // R2
    chip_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && acc_ok && reg_addr == 8'h10) |=> (reg_rdata == PORT_W'(CHIP_ID)));

    // R3
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && acc_ok && hole) |=> (reg_rdata == '0));

    // R6
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pp0 |-> (pin_out[PORT_W-1:0] == '0));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&msk) |-> int_n);

    // R11
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clr |=> ((&dir) && (lvl == '0)));

    // R12
    recover_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !acc_ok) |=> (reg_rdata == '0));
endmodule

bind pinx_core pinx_core_chk #(.PORT_W(PORT_W), .CHIP_ID(CHIP_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .pin_out(pin_out), .int_n(int_n),
    .acc_ok(acc_ok), .core_clr(core_clr), .pp0(pp0_q),
    .msk(msk_q), .dir(dir_q), .lvl(out_q)
);

// File: tb/pinx_core_tb.sv
module pinx_core_tb_top;
    localparam int FILT = 2000;
    localparam int REC  = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_rst_n = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;
    logic        int_n;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pinx_core #(.PORT_W(8), .FILT_CYCLES(FILT), .REC_CYCLES(REC), .CHIP_ID(8'h23)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .int_n(int_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_defaults;
        logic [7:0] d;
        rd(8'h02, d); chk("R1 out0", d, 8'h00);
        rd(8'h05, d); chk("R1 dir1", d, 8'hFF);
        rd(8'h06, d); chk("R1 msk0", d, 8'hFF);
        rd(8'h13, d); chk("R1 mode1", d, 8'hFF);
        rd(8'h11, d); chk("R1 gctl", d, 8'h00);
        chk("R1 oe", pin_oe, 16'h0000);
        chk("R1 int_n", int_n, 1'b1);
    endtask

    task automatic t_chip_id;
        logic [7:0] d;
        wr(8'h10, 8'h5A);
        rd(8'h10, d); chk("R2 id", d, 8'h23);
        idle(2); chk("R2 hold", reg_rdata, 8'h23);
    endtask

    task automatic t_holes;
        logic [7:0] d;
        wr(8'h08, 8'h00);
        wr(8'h20, 8'h11);
        rd(8'h08, d); chk("R3 hole08", d, 8'h00);
        rd(8'h7F, d); chk("R3 srst read", d, 8'h00);
        rd(8'h04, d); chk("R3 dir0 untouched", d, 8'hFF);
    endtask

    task automatic t_input;
        logic [7:0] d;
        pin_in = 16'hC381;
        idle(3);
        wr(8'h00, 8'h00);
        rd(8'h00, d); chk("R4 in0", d, 8'h81);
        rd(8'h01, d); chk("R4 in1", d, 8'hC3);
        pin_in = 16'h0000;
        idle(3);
        rd(8'h00, d); chk("R4 in0 zero", d, 8'h00);
        rd(8'h01, d);
    endtask

    task automatic t_push_pull;
        wr(8'h05, 8'hF0); wr(8'h03, 8'hA5);
        chk("R5 p1 oe", pin_oe[15:8], 8'h0F);
        chk("R5 p1 out", pin_out[15:8], 8'h05);
        wr(8'h11, 8'h10); wr(8'h04, 8'h00); wr(8'h02, 8'h3C);
        chk("R5 p0 oe", pin_oe[7:0], 8'hFF);
        chk("R5 p0 out", pin_out[7:0], 8'h3C);
    endtask

    task automatic t_open_drain;
        wr(8'h11, 8'h00);
        chk("R6 p0 oe", pin_oe[7:0], 8'hC3);
        chk("R6 p0 out", pin_out[7:0], 8'h00);
        chk("R6 p1 unchanged", pin_oe[15:8], 8'h0F);
    endtask

    task automatic t_mode_off;
        wr(8'h12, 8'h0F);
        chk("R7 p0 oe", pin_oe[7:0], 8'h03);
        wr(8'h11, 8'h10);
        chk("R7 p0 pp oe", pin_oe[7:0], 8'h0F);
        chk("R7 p0 pp out", pin_out[7:0], 8'h0C);
        wr(8'h13, 8'h00);
        chk("R7 p1 off", {pin_oe[15:8], pin_out[15:8]}, 16'h0000);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        wr(8'h06, 8'h00); wr(8'h07, 8'h00);
        idle(3); chk("R8 idle high", int_n, 1'b1);
        pin_in = 16'h0408;
        idle(4); chk("R8 rise low", int_n, 1'b0);
        rd(8'h01, d); chk("R4 in1 irq", d, 8'h04);
        idle(2); chk("R9 other port pending", int_n, 1'b0);
        rd(8'h00, d); chk("R4 in0 irq", d, 8'h08);
        idle(2); chk("R9 cleared", int_n, 1'b1);
        pin_in = 16'h0400;
        idle(4); chk("R8 fall low", int_n, 1'b0);
        rd(8'h00, d);
        idle(2); chk("R9 cleared fall", int_n, 1'b1);
        wr(8'h06, 8'h01);
        pin_in = 16'h0401;
        idle(4); chk("R8 masked", int_n, 1'b1);
        pin_in = 16'h0400;
        idle(4); chk("R8 masked back", int_n, 1'b1);
    endtask

    task automatic t_soft_reset;
        logic [7:0] d;
        wr(8'h04, 8'h00);
        wr(8'h7F, 8'h01);
        rd(8'h04, d); chk("R10 nonzero ignored", d, 8'h00);
        wr(8'h7F, 8'h00);
        rd(8'h04, d); chk("R10 dir0", d, 8'hFF);
        rd(8'h02, d); chk("R10 out0", d, 8'h00);
        rd(8'h06, d); chk("R10 msk0", d, 8'hFF);
        chk("R10 oe", pin_oe, 16'h0000);
    endtask

    task automatic t_hw_reset;
        logic [7:0] d;
        wr(8'h04, 8'h00);
        @(negedge clk); hw_rst_n = 1'b0;
        idle(FILT / 2);
        hw_rst_n = 1'b1;
        idle(5);
        rd(8'h04, d); chk("R11 short pulse ignored", d, 8'h00);
        hw_rst_n = 1'b0;
        idle(FILT + 20);
        hw_rst_n = 1'b1;
        idle(6);
        wr(8'h02, 8'h55);
        rd(8'h02, d); chk("R12 read blocked", d, 8'h00);
        idle(REC + 20);
        rd(8'h02, d); chk("R12 write ignored", d, 8'h00);
        rd(8'h04, d); chk("R11 dir0 default", d, 8'hFF);
        wr(8'h02, 8'h55);
        rd(8'h02, d); chk("R12 access back", d, 8'h55);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        t_defaults();
        t_chip_id();
        t_holes();
        t_input();
        t_push_pull();
        t_open_drain();
        t_mode_off();
        t_irq();
        t_soft_reset();
        t_hw_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule